// File: doc/BRIEF.md
# Periodic interval timer

This block is a memory-mapped periodic tick source. A fixed divide-by-16 prescaler drives a 20-bit counter that counts up from zero to a programmed limit and then returns to zero. Each return to zero is an interval event. An event sets a status flag and adds one to a 12-bit event count. The interrupt line is high while the flag is set and interrupts are enabled. Software uses it as a periodic interrupt source, and also as a free-running time base by combining the event count with the live counter value.

Access is through a simple 32-bit word bus with select, write-enable, address and data. Read data is combinational and valid in the cycle the access is presented. Any side effect of an access takes place at the clock edge that ends that cycle.

Two read locations return the same snapshot. One of them acknowledges the event: it clears the flag and resets the event count. The other leaves all state as it was. When the timer is disabled, the counter does not stop at once. It runs on to its next return to zero and then stays parked there.

Top module: `pit_timer`

## Requirements
- R1: After reset the mode, status and snapshot locations all read zero and irq_o is low.
- R2: Offset 0x00 is the mode word: bit 25 enables the interrupt, bit 24 enables counting and bits 19:0 hold the limit. On readback, every other bit reads zero.
- R3: While counting, the counter advances once every 16 clock cycles. Its first advance takes place at the 16th edge after the edge that enables it.
- R4: With limit N the counter wraps from N to 0, so the period is N+1 prescaled ticks. Each wrap sets the flag, read as bit 0 of offset 0x04, and adds one to the event count. A counter value at or above the limit also wraps on the next tick.
- R5: Offsets 0x08 and 0x0C both return the event count in bits 31:20 and the counter value in bits 19:0.
- R6: A read of 0x08 clears the flag and the event count at the end of the access. If a wrap happens on that same edge, the wrap takes precedence: the flag stays set and the count becomes 1.
- R7: A read of 0x0C changes no state.
- R8: irq_o is high exactly when the flag is set and the interrupt enable bit is set. Clearing the enable masks the line without clearing the flag.
- R9: After counting is disabled, the counter keeps advancing until it wraps to zero. It then holds at zero. That final wrap still counts as an event.
- R10: Reads of any offset other than 0x00, 0x04, 0x08 and 0x0C return zero. Writes to any offset other than 0x00 have no effect.
- R11: The event count wraps modulo 4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Access strobe, one access per cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte offset, word aligned |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Level interrupt |

## Verification
The properties assume the bus presents at most one access per cycle, at word-aligned offsets. They also assume that a read strobe stands for exactly one cycle, because every cycle of a held read of 0x08 is a separate acknowledge. The bench drives each access for a single cycle from a negative edge. It times every read against its own count of edges since the enabling write, so the expected counter, event count and flag follow from the prescale and period arithmetic. The acknowledge/wrap collision is exercised by placing a read of 0x08 in the cycle just before a wrap edge.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned DATA_W       = 32;
  localparam int unsigned OFS_MODE     = 'h00;
  localparam int unsigned OFS_STAT     = 'h04;
  localparam int unsigned OFS_VAL      = 'h08;
  localparam int unsigned OFS_IMG      = 'h0C;
  localparam int unsigned MODE_IEN_BIT = 25;
  localparam int unsigned MODE_EN_BIT  = 24;
endpackage

// File: rtl/pit_prescale.sv
module pit_prescale #(
  parameter int unsigned DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] presc_q;

  // held at zero while idle so a fresh enable starts a full prescale period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              presc_q <= '0;
    else if (!run_i)          presc_q <= '0;
    else if (presc_q == LAST) presc_q <= '0;
    else                      presc_q <= presc_q + W'(1);
  end

  assign tick_o = run_i && (presc_q == LAST);

  a_r3_tick_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (presc_q == '0));
endmodule

// File: rtl/pit_core.sv
module pit_core #(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned OVF_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             ack_i,
  input  logic [CNT_W-1:0] piv_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [OVF_W-1:0] ovf_o,
  output logic             flag_o,
  output logic             run_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [OVF_W-1:0] ovf_q;
  logic             flag_q;
  logic             wrap;

  assign wrap  = tick_i && (cnt_q >= piv_i);
  assign run_o = en_i || (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ovf_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (tick_i) cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
      // a wrap on the acknowledge edge is kept, not lost
      if (wrap) begin
        flag_q <= 1'b1;
        ovf_q  <= ack_i ? OVF_W'(1) : ovf_q + OVF_W'(1);
      end else if (ack_i) begin
        flag_q <= 1'b0;
        ovf_q  <= '0;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign ovf_o  = ovf_q;
  assign flag_o = flag_q;

  a_r3_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q == '0)));
  a_r4_flag_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> (cnt_q == '0));
  a_r6_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !tick_i) |=> (!flag_q && (ovf_q == '0)));
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && (cnt_q == '0)) |=> (cnt_q == '0));
  a_r11_ovf_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q != $past(ovf_q)) |-> ((ovf_q == $past(ovf_q) + OVF_W'(1)) || (ovf_q <= OVF_W'(1))));
endmodule

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned OVF_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [OVF_W-1:0]  ovf_i,
  input  logic              flag_i,
  output logic              en_o,
  output logic              ien_o,
  output logic [CNT_W-1:0]  piv_o,
  output logic              ack_o
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_VAL  = ADDR_W'(OFS_VAL);
  localparam logic [ADDR_W-1:0] A_IMG  = ADDR_W'(OFS_IMG);

  logic             en_q, ien_q;
  logic [CNT_W-1:0] piv_q;
  logic             mode_wr;
  logic             unused_wdata;

  assign mode_wr      = sel_i && we_i && (addr_i == A_MODE);
  assign ack_o        = sel_i && !we_i && (addr_i == A_VAL);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      ien_q <= 1'b0;
      piv_q <= '0;
    end else if (mode_wr) begin
      en_q  <= wdata_i[MODE_EN_BIT];
      ien_q <= wdata_i[MODE_IEN_BIT];
      piv_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i && !we_i) begin
      unique case (addr_i)
        A_MODE: begin
          rdata_o[MODE_IEN_BIT] = ien_q;
          rdata_o[MODE_EN_BIT]  = en_q;
          rdata_o[CNT_W-1:0]    = piv_q;
        end
        A_STAT:       rdata_o[0] = flag_i;
        A_VAL, A_IMG: rdata_o = DATA_W'({ovf_i, cnt_i});
        default:      rdata_o = '0;
      endcase
    end
  end

  assign en_o  = en_q;
  assign ien_o = ien_q;
  assign piv_o = piv_q;

  a_r10_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && (addr_i != A_MODE)) |=> ($stable(piv_q) && $stable(en_q) && $stable(ien_q)));
endmodule

// File: rtl/pit_timer.sv
module pit_timer #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned OVF_W  = 12,
  parameter int unsigned DIV    = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_sel_i,
  input  logic        bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        irq_o
);
  logic             en, ien, ack, tick, run, flag;
  logic [CNT_W-1:0] piv, cnt;
  logic [OVF_W-1:0] ovf;

  pit_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .OVF_W(OVF_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sel_i(bus_sel_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .cnt_i(cnt), .ovf_i(ovf), .flag_i(flag),
    .en_o(en), .ien_o(ien), .piv_o(piv), .ack_o(ack)
  );

  pit_prescale #(.DIV(DIV)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .tick_o(tick)
  );

  pit_core #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .tick_i(tick), .ack_i(ack),
    .piv_i(piv), .cnt_o(cnt), .ovf_o(ovf), .flag_o(flag), .run_o(run)
  );

  assign irq_o = flag && ien;

  a_r8_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && !bus_we_i && (bus_addr_i == ADDR_W'(pit_pkg::OFS_STAT)) && !bus_rdata_o[0]) |-> !irq_o);
endmodule

// File: tb/tb_pit_timer.sv
module tb_pit_timer;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic [31:0] exp;
    logic [4:0]  addr;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  int edges    = 0;
  int t0       = 0;
  item_t q[$];
  item_t it;

  pit_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  // monitor: compares each read against the queued expectation
  always begin
    @(negedge clk);
    #1;
    if (sel && !we) begin
      n_checks++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard empty addr=%h got=%h exp=none", addr, rdata);
      end else begin
        it = q.pop_front();
        if (rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s addr=%h got=%h exp=%h", it.tag, it.addr, rdata, it.exp);
        end
      end
    end
  end

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, input logic [31:0] e, input string tag);
    item_t x;
    x.exp = e; x.addr = a; x.tag = tag;
    q.push_back(x);
    sel = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic check_irq(input logic e, input string tag);
    n_checks++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s irq got=%b exp=%b", tag, irq, e);
    end
  endtask

  task automatic wait_to(input int tt);
    while (edges - t0 < tt) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1
    bus_read(5'h00, 32'h0, "R1 mode");
    bus_read(5'h04, 32'h0, "R1 stat");
    bus_read(5'h0C, 32'h0, "R1 img");
    bus_read(5'h08, 32'h0, "R1 val");
    check_irq(1'b0, "R1");

    // R2: reserved bits read zero, disabled counter stays idle
    bus_write(5'h00, 32'hFCFF_FFFF);
    bus_read(5'h00, 32'h000F_FFFF, "R2 mask");
    repeat (40) @(negedge clk);
    bus_read(5'h0C, 32'h0, "R9 idle stays zero");

    // R10 writes elsewhere ignored
    bus_write(5'h04, 32'hFFFF_FFFF);
    bus_write(5'h0C, 32'hFFFF_FFFF);
    bus_read(5'h04, 32'h0, "R10 stat write ignored");
    bus_read(5'h0C, 32'h0, "R10 img write ignored");

    // enable, limit 3, irq enabled
    bus_write(5'h00, 32'h0300_0003);
    t0 = edges;
    bus_read(5'h00, 32'h0300_0003, "R2 readback");
    wait_to(15); bus_read(5'h0C, 32'h0000_0000, "R3 before first tick");
    bus_read(5'h0C, 32'h0000_0001, "R3 first tick");
    wait_to(47); bus_read(5'h0C, 32'h0000_0002, "R3 cnt2");
    bus_read(5'h0C, 32'h0000_0003, "R3 cnt3");
    wait_to(63); check_irq(1'b0, "R8 before wrap");
    bus_read(5'h04, 32'h0, "R4 flag before wrap");
    bus_read(5'h0C, 32'h0010_0000, "R4 wrap to zero");
    bus_read(5'h04, 32'h1, "R4 flag set");
    check_irq(1'b1, "R8 raised");

    // R5 / R7
    wait_to(146);
    bus_read(5'h0C, 32'h0020_0001, "R5 snapshot fields");
    bus_read(5'h0C, 32'h0020_0001, "R7 image no effect");
    bus_read(5'h04, 32'h1, "R7 flag kept");
    check_irq(1'b1, "R7 irq kept");

    // R6 acknowledge
    bus_read(5'h08, 32'h0020_0001, "R6 value read");
    bus_read(5'h04, 32'h0, "R6 flag cleared");
    check_irq(1'b0, "R6 irq dropped");
    bus_read(5'h0C, 32'h0000_0001, "R6 count cleared");

    // R6 collision: ack on wrap edge
    wait_to(191);
    bus_read(5'h08, 32'h0000_0003, "R6 ack before wrap");
    bus_read(5'h0C, 32'h0010_0000, "R6 wrap wins count");
    bus_read(5'h04, 32'h1, "R6 wrap wins flag");

    // R8 mask
    bus_write(5'h00, 32'h0100_0003);
    check_irq(1'b0, "R8 masked");
    bus_read(5'h04, 32'h1, "R8 flag kept when masked");
    bus_write(5'h00, 32'h0300_0003);
    check_irq(1'b1, "R8 unmasked");

    // R9 disable mid-period
    wait_to(211);
    bus_write(5'h00, 32'h0000_0003);
    wait_to(242); bus_read(5'h0C, 32'h0010_0003, "R9 still running");
    wait_to(277); bus_read(5'h0C, 32'h0020_0000, "R9 parked at zero");
    wait_to(400); bus_read(5'h0C, 32'h0020_0000, "R9 stays parked");
    check_irq(1'b0, "R8 disabled ien");

    // R10 unmapped
    bus_read(5'h10, 32'h0, "R10 unmapped 0x10");
    bus_read(5'h14, 32'h0, "R10 unmapped 0x14");
    bus_read(5'h00, 32'h0000_0003, "R10 mode intact");

    // R11 count wraps at 4096, limit 0
    bus_read(5'h08, 32'h0020_0000, "R6 ack before R11");
    bus_write(5'h00, 32'h0100_0000);
    t0 = edges;
    wait_to(16*4095 + 3); bus_read(5'h0C, 32'hFFF0_0000, "R11 count max");
    wait_to(16*4096 + 3); bus_read(5'h0C, 32'h0000_0000, "R11 count wrapped");
    bus_read(5'h04, 32'h1, "R4 limit zero flag");

    #2;
    n_checks++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard leftover got=%0d exp=0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule